// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the host side of a two-wire serial bus and brings the bus back to a usable state after a transfer was cut short, for example by a reset of the host part way through a byte. A target that was sending a zero bit at that moment keeps holding the data line low. It lets go only after it has seen enough clock pulses to finish the byte.

On a one-cycle request the sequencer pulses the clock line, up to nine times, and samples the data line in the middle of each high phase. At the first pulse that finds the data line released, it pulls the data line low while the clock stays high. This is a start condition, so the bus is owned and ready for a fresh transfer, and the block reports success. If the data line is still low after the last pulse, it releases both lines and reports failure.

Both lines are open-drain, so the outputs are pull-low enables. The data input passes through a two-flop synchronizer. The phase timing comes from an internal divider, one quarter of a clock period being `QUARTER` system clocks.

Top module: `twi_bus_recover`

## Requirements
- R1: Out of reset both pull-low enables are 0, and `busy`, `done` and `fail` are 0.
- R2: A request taken while idle starts a sequence on the next clock. Every clock pulse is a low phase followed by a high phase, and each phase lasts exactly 2*`QUARTER` system clocks.
- R3: One sequence never produces more than `MAX_PULSES` (default 9) clock pulses. A pulse is counted at each falling edge of the clock line while `busy` is 1.
- R4: The data line is sampled once per pulse, one quarter period after the clock rises. Pulsing stops at the first pulse whose sample reads high. When a target holds the data line low until it has seen K clock falling edges, with K ≤ 9, the sequence uses max(K,1) pulses.
- R5: On success the data enable rises while the clock line is high and has been high on the previous clock as well (a start condition). The clock line then stays high for 2*`QUARTER` clocks, after which `done` is 1 for one clock.
- R6: If every sample of the sequence reads low, `fail` is 1 for one clock after the last pulse, and both enables are 0 from that clock on.
- R7: A request that arrives while `busy` is 1 is ignored. The pulse count and the outcome are the same as without it, and no further sequence follows.
- R8: Apart from the start condition, the data line never changes while the clock line is high. After success the data line stays pulled low until the first low phase of the next sequence.
- R9: `done` and `fail` are never 1 in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recover_req | input | 1 | One-cycle request to run a recovery sequence |
| sda_in | input | 1 | Sensed level of the data line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse: start condition issued |
| fail | output | 1 | One-cycle pulse: data line still low after the last pulse |

## Verification
The bench builds the block with `QUARTER` = 4 and the default `MAX_PULSES` = 9. A full pulse then takes 16 system clocks, so targets that release after 0, 1, 3, 8 and 9 falling edges, and stuck targets that never release in time, all finish in a few hundred cycles. A quarter of 4 is still longer than the synchronizer and target-model latency, so the mid-high sample sees a release made in the preceding low phase. The same short period leaves room for back-to-back sequences and for a second request injected mid-sequence.

// File: rtl/twi_bus_recover.sv
module twi_bus_recover #(
  parameter int QUARTER    = 8,
  parameter int MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recover_req,
  input  logic sda_in,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done,
  output logic fail
);

  localparam int QW = (QUARTER > 1) ? $clog2(QUARTER) : 1;
  localparam int PW = $clog2(MAX_PULSES + 1);

  typedef enum logic [1:0] {S_IDLE, S_CLK, S_START} st_t;

  st_t           st;
  logic [QW-1:0] qcnt;
  logic [1:0]    ph;
  logic [PW-1:0] pcnt;
  logic          hold_sda;
  logic [1:0]    sync;

  wire tick   = (qcnt == QW'(QUARTER - 1));
  wire sda_hi = sync[1];

  assign scl_oe = (st == S_CLK) && !ph[1];
  assign sda_oe = (st == S_START) || hold_sda;
  assign busy   = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      qcnt     <= '0;
      ph       <= '0;
      pcnt     <= '0;
      hold_sda <= 1'b0;
      sync     <= 2'b00;
      done     <= 1'b0;
      fail     <= 1'b0;
    end else begin
      sync <= {sync[0], sda_in};
      done <= 1'b0;
      fail <= 1'b0;
      case (st)
        S_IDLE: begin
          qcnt <= '0;
          ph   <= '0;
          pcnt <= '0;
          if (recover_req) st <= S_CLK;
        end
        S_CLK: begin
          qcnt <= tick ? '0 : qcnt + QW'(1);
          if (tick) begin
            ph <= ph + 2'd1;
            if (ph == 2'd0) hold_sda <= 1'b0;
            if (ph == 2'd2 && sda_hi) begin
              st <= S_START;
              ph <= 2'd0;
            end
            if (ph == 2'd3) begin
              if (pcnt == PW'(MAX_PULSES - 1)) begin
                st   <= S_IDLE;
                fail <= 1'b1;
              end else begin
                pcnt <= pcnt + PW'(1);
              end
            end
          end
        end
        S_START: begin
          qcnt <= tick ? '0 : qcnt + QW'(1);
          if (tick) begin
            ph <= ph + 2'd1;
            if (ph == 2'd1) begin
              st       <= S_IDLE;
              done     <= 1'b1;
              hold_sda <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_pulse_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt < PW'(MAX_PULSES));

  p_start_cond_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> (!scl_oe && $past(!scl_oe)));

  p_done_owns_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sda_oe && !scl_oe && $past(st == S_START)));

  p_fail_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!sda_oe && !scl_oe));

  p_fresh_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CLK && pcnt == '0 && ph == 2'd0 && qcnt == '0) |-> $past(st == S_IDLE));

  p_sda_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && !$stable(sda_oe)) |-> sda_oe);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

endmodule

// File: tb/sim_twi_bus_recover.sv
module sim_twi_bus_recover;
  localparam int Q   = 4;
  localparam int MAXP = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recover_req = 1'b0;
  logic scl_oe, sda_oe, busy, done, fail;
  logic tgt_low = 1'b0;
  wire  scl_line = ~scl_oe;
  wire  sda_line = ~(sda_oe | tgt_low);

  always #2 clk = ~clk;

  twi_bus_recover #(.QUARTER(Q), .MAX_PULSES(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .recover_req(recover_req), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done), .fail(fail));

  int n_chk = 0;
  int n_bad = 0;
  int q_ok[$];
  int q_pul[$];
  int tgt_need = 0;
  int tgt_seen = 0;
  bit tgt_arm = 0;
  int results = 0;

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor state
  bit prev_scl = 1, prev_sda = 1, prev_busy = 0, seg_ok = 0, start_seen = 0;
  int seg_len = 0, falls = 0, viol = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_line != prev_scl) begin
        if (seg_ok) check(seg_len == 2*Q, "R2 phase length", seg_len, 2*Q);
        seg_len = 1;
        seg_ok  = busy;
        if (!scl_line && busy) falls++;
      end else seg_len++;
      if (!busy) seg_ok = 0;
      if (scl_line && prev_scl && sda_line != prev_sda) begin
        if (!sda_line && busy) start_seen = 1;
        else viol++;
      end
      if (done || fail) begin
        results++;
        if (q_ok.size() == 0) check(0, "R7 unexpected result", results, 0);
        else begin
          int eok, ep;
          eok = q_ok.pop_front();
          ep  = q_pul.pop_front();
          check(done == eok[0], "R4/R6 outcome (done)", int'(done), eok);
          check(fail == !eok[0], "R6 outcome (fail)", int'(fail), int'(!eok[0]));
          check(falls == ep, "R3/R4 pulse count", falls, ep);
          if (eok != 0) begin
            check(start_seen, "R5 start condition seen", int'(start_seen), 1);
            check(scl_line && !sda_line, "R5 lines at done", int'({scl_line, sda_line}), 2);
          end else begin
            check(!scl_oe && !sda_oe, "R6 lines released", int'({scl_oe, sda_oe}), 0);
          end
        end
        falls = 0;
        start_seen = 0;
      end
      prev_busy = busy;
    end
    prev_scl = scl_line;
    prev_sda = sda_line;
    // target model: holds SDA low until it has seen tgt_need clock falls
    if (tgt_arm) begin
      tgt_seen = 0;
      tgt_arm  = 0;
    end else if (!scl_line && prev_scl_t) tgt_seen++;
    prev_scl_t = scl_line;
    tgt_low = (tgt_seen < tgt_need);
  end
  bit prev_scl_t = 1;

  task automatic run_case(input int k, input bit extra_req);
    int ep;
    ep = (k <= MAXP) ? ((k < 1) ? 1 : k) : MAXP;
    @(posedge clk); #1;
    tgt_need = k;
    tgt_arm  = 1;
    @(posedge clk); #1;
    q_ok.push_back((k <= MAXP) ? 1 : 0);
    q_pul.push_back(ep);
    recover_req = 1'b1;
    @(posedge clk); #1;
    recover_req = 1'b0;
    if (extra_req) begin
      repeat (20) @(posedge clk);
      #1;
      check(busy, "R7 busy when second request issued", int'(busy), 1);
      recover_req = 1'b1;
      @(posedge clk); #1;
      recover_req = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (30) @(negedge clk);
    check(!busy, "R7 no sequence after completion", int'(busy), 0);
    check(q_ok.size() == 0, "R4 result produced", q_ok.size(), 0);
    if (k <= MAXP)
      check(sda_oe && !scl_oe, "R8 bus held after success", int'({sda_oe, scl_oe}), 2);
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!scl_oe && !sda_oe, "R1 enables after reset", int'({scl_oe, sda_oe}), 0);
    check(!busy, "R1 busy after reset", int'(busy), 0);
    check(!done && !fail, "R1 pulses after reset", int'({done, fail}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!scl_oe && !sda_oe && !busy, "R1 idle after reset release", int'({scl_oe, sda_oe, busy}), 0);
    run_case(0, 0);
    run_case(1, 0);
    run_case(3, 0);
    run_case(8, 0);
    run_case(9, 0);
    run_case(10, 0);
    run_case(20, 0);
    run_case(2, 0);
    run_case(5, 1);
    run_case(12, 1);
    run_case(4, 0);
    check(viol == 0, "R8 SDA changes while SCL high", viol, 0);
    check(results == 11, "R7 result count", results, 11);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule